// File: doc/BRIEF.md
# Vector Control and Status Register File

This block holds the architectural control state of a vector unit: the start index (vstart), the active length (vl), the type word (vtype), the register width in bytes (vlenb), and a three-bit control word (vcsr) that packs the fixed-point rounding mode and the saturation flag. Software reaches these through a 12-bit CSR address. The rounding-mode and saturation addresses do not have storage of their own. They are narrow windows onto the two fields of the control word. Reading one returns the field, and writing one replaces that field alone.

Reads are combinational from the current state. A write takes effect at the next rising clock edge. The write-result output gives, in the same cycle, the zero-extended value that the addressed register will hold after the write. The datapath sets the saturation flag through a separate side port. VLEN and XLEN are elaboration parameters. Privilege checking, trap raising and the computation of vl and vtype are handled elsewhere.

Top module: `vec_csr_unit`

## Requirements
- R1: `csr_defined` is 1 exactly for the addresses 0x008 (start index), 0x009 (saturation view), 0x00A (rounding view), 0x00F (control word), 0xC20 (length), 0xC21 (type) and 0xC22 (width in bytes). A read of any other address returns 0.
- R2: The control word has the rounding mode in bits [2:1] and the saturation flag in bit 0. A read of 0x009 returns the flag, a read of 0x00A returns the rounding mode, and a read of 0x00F returns all three bits. Each is zero-extended to XLEN.
- R3: A write to 0x009 sets the saturation flag from write-data bit 0 and leaves the rounding mode unchanged.
- R4: A write to 0x00A sets the rounding mode from write-data bits [1:0] and leaves the saturation flag unchanged.
- R5: A write to 0x00F loads the rounding mode from bits [2:1] and the saturation flag from bit 0.
- R6: A write to 0x008 stores only the low log2(VLEN) bits of the write data, zero-extended into a 16-bit register.
- R7: During a write cycle, `csr_wresult` equals the value that a read of the same address returns after the clock edge.
- R8: After reset, the start index, the length and the control word read 0. The type reads with only bit XLEN-1 set. The width reads VLEN/8.
- R9: Writes to 0xC20, 0xC21 and 0xC22 store the full XLEN-bit write data.
- R10: When `sat_set` is high, the saturation flag takes the value of `sat_value` at the next edge. A CSR write to 0x009 or 0x00F in the same cycle takes priority over the port. A write to 0x00A in the same cycle does not block the port.
- R11: A write to an undefined address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address for the read and the write |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable |
| csr_rdata | output | XLEN | Current value at `csr_addr`, zero-extended |
| csr_wresult | output | XLEN | Value the addressed register holds after this write |
| csr_defined | output | 1 | Address belongs to this block |
| sat_set | input | 1 | Datapath saturation update strobe |
| sat_value | input | 1 | New saturation flag value |

## Verification
A wrong control-word field shows up on the first read of 0x009, 0x00A or 0x00F after the faulty write. The bench therefore reads the control word back in the cycle that follows every write, to catch corruption of the neighbouring field. A truncation fault in the start index, or a loss of priority against the side port, is visible one edge after the stimulus. Reset faults are visible on the ports before the first write.

// File: rtl/vec_csr_unit.sv
module vec_csr_unit #(
  parameter int XLEN = 64,
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  output logic [XLEN-1:0] csr_rdata,
  output logic [XLEN-1:0] csr_wresult,
  output logic            csr_defined,
  input  logic            sat_set,
  input  logic            sat_value
);
  localparam int VSW = $clog2(VLEN);
  localparam logic [XLEN-1:0] VTYPE_RST = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] VLENB_RST = XLEN'(VLEN / 8);

  logic [15:0]     vstart_q, vstart_d;
  logic [XLEN-1:0] vl_q, vl_d, vtype_q, vtype_d, vlenb_q, vlenb_d;
  logic [2:0]      vcsr_q, vcsr_d;

  function automatic logic [XLEN-1:0] view(input logic [11:0] a, input logic [15:0] vs,
      input logic [2:0] vc, input logic [XLEN-1:0] l, input logic [XLEN-1:0] t,
      input logic [XLEN-1:0] b);
    case (a)
      12'h008: view = XLEN'(vs);
      12'h009: view = XLEN'(vc[0]);
      12'h00A: view = XLEN'(vc[2:1]);
      12'h00F: view = XLEN'(vc);
      12'hC20: view = l;
      12'hC21: view = t;
      12'hC22: view = b;
      default: view = '0;
    endcase
  endfunction

  always_comb begin
    vstart_d = vstart_q;
    vl_d     = vl_q;
    vtype_d  = vtype_q;
    vlenb_d  = vlenb_q;
    vcsr_d   = vcsr_q;
    if (sat_set) vcsr_d[0] = sat_value;
    if (csr_we) begin
      case (csr_addr)
        12'h008: vstart_d    = 16'(csr_wdata[VSW-1:0]);
        12'h009: vcsr_d[0]   = csr_wdata[0];
        12'h00A: vcsr_d[2:1] = csr_wdata[1:0];
        12'h00F: vcsr_d      = csr_wdata[2:0];
        12'hC20: vl_d        = csr_wdata;
        12'hC21: vtype_d     = csr_wdata;
        12'hC22: vlenb_d     = csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vstart_q <= '0;
      vl_q     <= '0;
      vtype_q  <= VTYPE_RST;
      vlenb_q  <= VLENB_RST;
      vcsr_q   <= '0;
    end else begin
      vstart_q <= vstart_d;
      vl_q     <= vl_d;
      vtype_q  <= vtype_d;
      vlenb_q  <= vlenb_d;
      vcsr_q   <= vcsr_d;
    end
  end

  always_comb begin
    case (csr_addr)
      12'h008, 12'h009, 12'h00A, 12'h00F,
      12'hC20, 12'hC21, 12'hC22: csr_defined = 1'b1;
      default:                   csr_defined = 1'b0;
    endcase
  end

  assign csr_rdata   = view(csr_addr, vstart_q, vcsr_q, vl_q, vtype_q, vlenb_q);
  assign csr_wresult = view(csr_addr, vstart_d, vcsr_d, vl_d, vtype_d, vlenb_d);

  assert_undef_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_defined |-> csr_rdata == '0);

  assert_undef_write_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_defined && !sat_set) |=>
      ($stable(vstart_q) && $stable(vl_q) && $stable(vtype_q) && $stable(vlenb_q) && $stable(vcsr_q)));

  assert_vstart_trunc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h008) |=> vstart_q == 16'($past(csr_wdata[VSW-1:0])));

  assert_vxrm_write_keeps_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h00A && !sat_set) |=>
      (vcsr_q[2:1] == $past(csr_wdata[1:0]) && $stable(vcsr_q[0])));

  assert_csr_beats_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && sat_set && (csr_addr == 12'h009 || csr_addr == 12'h00F)) |=>
      vcsr_q[0] == $past(csr_wdata[0]));
endmodule

// File: tb/vec_csr_unit_bench.sv
module vec_csr_unit_bench;
  localparam int XLEN = 64;
  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_rdata, csr_wresult;
  logic            csr_defined;
  logic            sat_set = 1'b0;
  logic            sat_value = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  vec_csr_unit #(.XLEN(XLEN), .VLEN(VLEN)) u_vec_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .csr_wresult(csr_wresult),
    .csr_defined(csr_defined), .sat_set(sat_set), .sat_value(sat_value)
  );

  typedef struct packed {
    logic [11:0]     addr;
    logic [XLEN-1:0] wdata;
    logic [XLEN-1:0] expv;
    logic [2:0]      vcsr_after;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{12'h009, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3'b001},
    '{12'h00A, 64'hFFFF_FFFF_FFFF_FFFE, 64'h2, 3'b101},
    '{12'h00F, 64'h0000_0000_0000_0006, 64'h6, 3'b110},
    '{12'h009, 64'h0000_0000_0000_0001, 64'h1, 3'b111},
    '{12'h00A, 64'h0000_0000_0000_0000, 64'h0, 3'b001},
    '{12'h00F, 64'h0000_0000_0000_00F8, 64'h0, 3'b000},
    '{12'h008, 64'h0000_0000_0000_FFFF, 64'h7F, 3'b000},
    '{12'h008, 64'h0000_0000_1234_5685, 64'h05, 3'b000},
    '{12'hC20, 64'hDEAD_BEEF_0000_0011, 64'hDEAD_BEEF_0000_0011, 3'b000},
    '{12'hC21, 64'h8000_0000_0000_00C3, 64'h8000_0000_0000_00C3, 3'b000},
    '{12'hC22, 64'h0000_0000_0000_0020, 64'h20, 3'b000}
  };

  task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [XLEN-1:0] exp);
    @(negedge clk);
    csr_we = 1'b0;
    csr_addr = a;
    #1 check(req, csr_rdata, exp);
  endtask

  task automatic write(input logic [11:0] a, input logic [XLEN-1:0] d, input logic s, input logic sv);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1; sat_set = s; sat_value = sv;
    @(posedge clk);
    #1 csr_we = 1'b0; sat_set = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 reset values
    read_chk("R8 vstart", 12'h008, 64'h0);
    read_chk("R8 vl", 12'hC20, 64'h0);
    read_chk("R8 vcsr", 12'h00F, 64'h0);
    read_chk("R8 vtype", 12'hC21, 64'h8000_0000_0000_0000);
    read_chk("R8 vlenb", 12'hC22, 64'(VLEN / 8));

    // R1 decode
    foreach (VECS[i]) begin
      @(negedge clk); csr_addr = VECS[i].addr;
      #1 check("R1 defined", 64'(csr_defined), 64'h1);
    end
    read_chk("R1 undef 0x00B reads 0", 12'h00B, 64'h0);
    #1 check("R1 0x00B not defined", 64'(csr_defined), 64'h0);
    read_chk("R1 undef 0xC23 reads 0", 12'hC23, 64'h0);
    #1 check("R1 0xC23 not defined", 64'(csr_defined), 64'h0);
    read_chk("R1 undef 0x7A0 reads 0", 12'h7A0, 64'h0);
    #1 check("R1 0x7A0 not defined", 64'(csr_defined), 64'h0);

    // Table: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      csr_addr = VECS[i].addr; csr_wdata = VECS[i].wdata; csr_we = 1'b1;
      #1 check("R7 write result", csr_wresult, VECS[i].expv);
      @(posedge clk);
      #1 csr_we = 1'b0;
      check("R3/R4/R5/R6/R9 readback", csr_rdata, VECS[i].expv);
      read_chk("R2 vcsr view", 12'h00F, 64'(VECS[i].vcsr_after));
    end
    read_chk("R2 vxsat view", 12'h009, 64'h0);
    read_chk("R2 vxrm view", 12'h00A, 64'h0);

    // R11 undefined write
    write(12'h00B, '1, 1'b0, 1'b0);
    read_chk("R11 vcsr held", 12'h00F, 64'h0);
    read_chk("R11 vstart held", 12'h008, 64'h05);
    read_chk("R11 vl held", 12'hC20, 64'hDEAD_BEEF_0000_0011);

    // R10 saturation port
    write(12'h000, '0, 1'b1, 1'b1);
    read_chk("R10 sat port sets flag", 12'h009, 64'h1);
    read_chk("R10 sat port keeps vxrm", 12'h00A, 64'h0);
    write(12'h009, 64'h0, 1'b1, 1'b1);
    read_chk("R10 csr 0x009 beats port", 12'h009, 64'h0);
    write(12'h00F, 64'h4, 1'b1, 1'b1);
    read_chk("R10 csr 0x00F beats port", 12'h00F, 64'h4);
    write(12'h00A, 64'h3, 1'b1, 1'b1);
    read_chk("R10 port lands with 0x00A write", 12'h00F, 64'h7);
    write(12'h000, '0, 1'b1, 1'b0);
    read_chk("R10 port clears flag", 12'h00F, 64'h6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule